// File: doc/BRIEF.md
# ATA Single-Sector Read Sequencer

This block fetches one 512-byte sector from a CompactFlash card in ATA PIO mode with 28-bit LBA addressing and returns it as 256 sixteen-bit words, one for each request. A host first loads a sector address and then pulses a word request for each word it wants. When no sector is open, the block programs the task file and issues a read-sector command. It then polls status until the card offers data. After that, each request reads one word from the data register without checking status again.

All register cycles go to a separate register-access engine through a request/done handshake. The sequencer keeps a small local view of the card: whether a sector is open, whether data or a new command is allowed, and whether an error was seen. Words left over from a sector that was not finished are read and thrown away before a new command goes out. A status error starts a soft reset, after which the interrupted word request is retried from the start.

Top module: `ata_sector_reader`

## Requirements
- R1: While and just after reset, `regReq`, `wordValid` and `devError` are low.
- R2: Opening a sector writes seven registers in this order (register codes in brackets): feature [1] = 0x00, sector count [2] = 0x01, LBA bits 7:0 [3], LBA bits 15:8 [4], LBA bits 23:16 [5], drive/head [6], then command [7] = 0x20. Status reads use code 7 and data reads use code 0. Write data sits in `regWdata[7:0]` with the upper byte zero.
- R3: The drive/head value is 0xE0 ORed with LBA bits 27:24. This selects LBA mode and drive 0.
- R4: A status byte (in `regRdata[7:0]`) allows data when (status & 0xC9) == 0x48. After the read command, status is polled until this holds, and only then is the first data word read.
- R5: An opened sector serves 256 requests, each with a single data read and no status read. The request after the 256th opens a new sector at the same address.
- R6: Before a command, status is polled. While it allows data, one leftover word is read and dropped and status is polled again. While busy (neither data allowed nor (status & 0xC1) == 0x40), status is polled again. Once the command is allowed, the setup writes start.
- R7: A status byte with bit 0 set raises `devError` for the soft reset. The soft reset writes 0x04 to the device-control register (code 0xE), waits at least `RST_HOLD` cycles, then writes 0x00 to the same register.
- R8: After a soft reset the local status is cleared and the interrupted word request restarts with a status poll. A command is reissued and the requested word is still delivered.
- R9: Loading a new LBA while idle closes the open sector, so the next request drains any leftovers and opens the new address.
- R10: `regReq` with its address, direction and write data stays steady until `regDone`. `wordValid` is a one-cycle pulse.
- R11: `wordData` shown with `wordValid` equals the value returned by that request's data-register read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lbaLoad | input | 1 | Pulse: capture `lbaIn` (accepted while idle) |
| lbaIn | input | 28 | Sector address |
| wordReq | input | 1 | Pulse: fetch the next word (accepted while idle) |
| wordValid | output | 1 | One-cycle pulse: `wordData` is valid |
| wordData | output | 16 | Returned data word |
| devError | output | 1 | High while an error-triggered soft reset runs |
| regReq | output | 1 | Register cycle request to the access engine |
| regWrite | output | 1 | 1 = write, 0 = read |
| regAddr | output | 4 | Task-file register code |
| regWdata | output | 16 | Write data |
| regDone | input | 1 | One-cycle completion from the access engine |
| regRdata | input | 16 | Read data, valid with `regDone` |

## Verification
The assertions check some properties on every cycle. They check that a register request stays frozen until its completion and that `wordValid` never lasts two cycles. They check that soft-reset traffic only targets device control and that the command write always carries the read-sector opcode. They also check that a sector opens with a full word count that never underflows. Only the bench scenarios can show the rest, because it depends on how the card answers over many transactions. That covers the exact order of register operations, the drive/head encoding, and the count of 256 words before a new command. It also covers draining leftovers after an address change, waiting out busy status, the soft-reset hold time, and the retry that still delivers the right word.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
  localparam int LBA_W  = 28;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 4;
  localparam int SETUP_STEPS = 7;
  localparam int IDX_W  = $clog2(SETUP_STEPS);

  localparam logic [ADDR_W-1:0] REG_DATA   = 4'h0;
  localparam logic [ADDR_W-1:0] REG_FEAT   = 4'h1;
  localparam logic [ADDR_W-1:0] REG_SCNT   = 4'h2;
  localparam logic [ADDR_W-1:0] REG_LBA0   = 4'h3;
  localparam logic [ADDR_W-1:0] REG_LBA1   = 4'h4;
  localparam logic [ADDR_W-1:0] REG_LBA2   = 4'h5;
  localparam logic [ADDR_W-1:0] REG_DRVH   = 4'h6;
  localparam logic [ADDR_W-1:0] REG_CMDST  = 4'h7;
  localparam logic [ADDR_W-1:0] REG_DEVCTL = 4'hE;

  localparam logic [7:0] OP_READ_ONE = 8'h20;
  localparam logic [7:0] CTL_SRST    = 8'h04;
  localparam logic [7:0] DRVH_BASE   = 8'hE0;
  localparam logic [7:0] XFER_MASK   = 8'hC9;
  localparam logic [7:0] XFER_MATCH  = 8'h48;
  localparam logic [7:0] CMD_MASK    = 8'hC1;
  localparam logic [7:0] CMD_MATCH   = 8'h40;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE_POLL, S_PRE_EVAL, S_DRAIN, S_SETUP, S_POST_POLL,
    S_POST_EVAL, S_WORD, S_RESP, S_RST_ON, S_RST_WAIT, S_RST_OFF
  } seqState_t;

  typedef struct packed {
    logic lbaLoad;
    logic statusLatch;
    logic statusClr;
    logic sectorLoad;
    logic countDec;
    logic wordCapture;
    logic delayStart;
  } dpStrobe_t;

  typedef struct packed {
    logic avail;
    logic xferOk;
    logic cmdOk;
    logic err;
    logic delayDone;
  } dpFlags_t;
endpackage

// File: rtl/ata_seq_dp.sv
module ata_seq_dp
  import ata_seq_pkg::*;
#(
  parameter int WORDS    = 256,
  parameter int RST_HOLD = 6120
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [LBA_W-1:0]  lbaIn,
  input  logic [WORD_W-1:0] rdData,
  input  logic [IDX_W-1:0]  setupIdx,
  output dpFlags_t          flags,
  output logic [ADDR_W-1:0] setupAddr,
  output logic [7:0]        setupByte,
  output logic [WORD_W-1:0] wordOut
);
  localparam int CNT_W = $clog2(WORDS + 1);
  localparam int DLY_W = $clog2(RST_HOLD + 1);

  logic [LBA_W-1:0] lbaReg;
  logic [CNT_W-1:0] wordCnt;
  logic [DLY_W-1:0] dlyCnt;
  logic avail, xferOk, cmdOk, errFlag;
  logic [7:0] sts;

  assign sts = rdData[7:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lbaReg  <= '0;
      wordOut <= '0;
      wordCnt <= '0;
      dlyCnt  <= '0;
      avail   <= 1'b0;
      xferOk  <= 1'b0;
      cmdOk   <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (stb.lbaLoad) begin
        lbaReg <= lbaIn;
        avail  <= 1'b0;
      end
      if (stb.wordCapture) wordOut <= rdData;
      if (stb.statusClr) begin
        avail <= 1'b0; xferOk <= 1'b0; cmdOk <= 1'b0; errFlag <= 1'b0;
      end else if (stb.statusLatch) begin
        if (sts[0]) begin
          errFlag <= 1'b1; avail <= 1'b0; xferOk <= 1'b0; cmdOk <= 1'b0;
        end else begin
          xferOk <= ((sts & XFER_MASK) == XFER_MATCH);
          cmdOk  <= ((sts & CMD_MASK) == CMD_MATCH);
        end
      end
      if (stb.sectorLoad) begin
        avail   <= 1'b1;
        wordCnt <= CNT_W'(WORDS);
      end else if (stb.countDec) begin
        wordCnt <= wordCnt - 1'b1;
        if (wordCnt == CNT_W'(1)) avail <= 1'b0;
      end
      if (stb.delayStart)  dlyCnt <= DLY_W'(RST_HOLD);
      else if (dlyCnt != '0) dlyCnt <= dlyCnt - 1'b1;
    end
  end

  assign flags = '{avail: avail, xferOk: xferOk, cmdOk: cmdOk,
                   err: errFlag, delayDone: (dlyCnt == '0)};

  always_comb begin
    setupAddr = REG_CMDST;
    setupByte = OP_READ_ONE;
    case (setupIdx)
      IDX_W'(0): begin setupAddr = REG_FEAT; setupByte = 8'h00;          end
      IDX_W'(1): begin setupAddr = REG_SCNT; setupByte = 8'h01;          end
      IDX_W'(2): begin setupAddr = REG_LBA0; setupByte = lbaReg[7:0];    end
      IDX_W'(3): begin setupAddr = REG_LBA1; setupByte = lbaReg[15:8];   end
      IDX_W'(4): begin setupAddr = REG_LBA2; setupByte = lbaReg[23:16];  end
      IDX_W'(5): begin setupAddr = REG_DRVH; setupByte = DRVH_BASE | {4'h0, lbaReg[27:24]}; end
      default:   begin setupAddr = REG_CMDST; setupByte = OP_READ_ONE;   end
    endcase
  end

  // R5: a word is never consumed from an empty sector count
  p_dec_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.countDec |-> (wordCnt != '0));
  // R5: a sector opens with the full word budget
  p_open_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(avail) |-> (wordCnt == CNT_W'(WORDS)));
  // R7: an error leaves only the error flag set
  p_err_alone_r7: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (!avail && !xferOk && !cmdOk));
endmodule

// File: rtl/ata_seq_ctrl.sv
module ata_seq_ctrl
  import ata_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lbaLoad,
  input  logic              wordReq,
  input  logic              regDone,
  input  dpFlags_t          flags,
  input  logic [ADDR_W-1:0] setupAddr,
  input  logic [7:0]        setupByte,
  output logic              regReq,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [WORD_W-1:0] regWdata,
  output logic              wordValid,
  output logic              devError,
  output dpStrobe_t         stb,
  output logic [IDX_W-1:0]  setupIdx
);
  seqState_t state, nextState;
  logic [IDX_W-1:0] nextIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      setupIdx <= '0;
    end else begin
      state    <= nextState;
      setupIdx <= nextIdx;
    end
  end

  always_comb begin
    nextState = state;
    nextIdx   = setupIdx;
    stb       = '0;
    regReq    = 1'b0;
    regWrite  = 1'b0;
    regAddr   = REG_DATA;
    regWdata  = '0;
    wordValid = 1'b0;
    devError  = 1'b0;
    case (state)
      S_IDLE: begin
        if (lbaLoad) stb.lbaLoad = 1'b1;
        else if (wordReq) nextState = flags.avail ? S_WORD : S_PRE_POLL;
      end
      S_PRE_POLL, S_POST_POLL: begin
        regReq = 1'b1; regAddr = REG_CMDST;
        if (regDone) begin
          stb.statusLatch = 1'b1;
          nextState = (state == S_PRE_POLL) ? S_PRE_EVAL : S_POST_EVAL;
        end
      end
      S_PRE_EVAL: begin
        if (flags.err)         nextState = S_RST_ON;
        else if (flags.xferOk) nextState = S_DRAIN;
        else if (flags.cmdOk) begin nextIdx = '0; nextState = S_SETUP; end
        else                   nextState = S_PRE_POLL;
      end
      S_DRAIN: begin
        regReq = 1'b1; regAddr = REG_DATA;
        if (regDone) nextState = S_PRE_POLL;
      end
      S_SETUP: begin
        regReq = 1'b1; regWrite = 1'b1; regAddr = setupAddr;
        regWdata = {8'h00, setupByte};
        if (regDone) begin
          if (setupIdx == IDX_W'(SETUP_STEPS - 1)) begin
            nextIdx = '0; nextState = S_POST_POLL;
          end else nextIdx = setupIdx + 1'b1;
        end
      end
      S_POST_EVAL: begin
        if (flags.err) nextState = S_RST_ON;
        else if (flags.xferOk) begin stb.sectorLoad = 1'b1; nextState = S_WORD; end
        else nextState = S_POST_POLL;
      end
      S_WORD: begin
        regReq = 1'b1; regAddr = REG_DATA;
        if (regDone) begin
          stb.wordCapture = 1'b1; stb.countDec = 1'b1; nextState = S_RESP;
        end
      end
      S_RESP: begin
        wordValid = 1'b1; nextState = S_IDLE;
      end
      S_RST_ON: begin
        devError = 1'b1; regReq = 1'b1; regWrite = 1'b1;
        regAddr = REG_DEVCTL; regWdata = {8'h00, CTL_SRST};
        if (regDone) begin stb.delayStart = 1'b1; nextState = S_RST_WAIT; end
      end
      S_RST_WAIT: begin
        devError = 1'b1;
        if (flags.delayDone) nextState = S_RST_OFF;
      end
      S_RST_OFF: begin
        devError = 1'b1; regReq = 1'b1; regWrite = 1'b1; regAddr = REG_DEVCTL;
        if (regDone) begin stb.statusClr = 1'b1; nextState = S_PRE_POLL; end
      end
      default: nextState = S_IDLE;
    endcase
  end

  // R10: a pending register cycle is held frozen until completion
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regDone) |=> (regReq && $stable(regAddr) && $stable(regWrite) && $stable(regWdata)));
  // R10: the word strobe lasts one cycle
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);
  // R7: soft-reset traffic only goes to device control
  p_rst_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    (devError && regReq) |-> (regWrite && regAddr == REG_DEVCTL));
  // R2: any write to the command register is the read-sector opcode
  p_cmd_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regWrite && regAddr == REG_CMDST) |-> (regWdata == {8'h00, OP_READ_ONE}));
endmodule

// File: rtl/ata_sector_reader.sv
module ata_sector_reader
  import ata_seq_pkg::*;
#(
  parameter int WORDS    = 256,
  parameter int RST_HOLD = 6120
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lbaLoad,
  input  logic [27:0] lbaIn,
  input  logic        wordReq,
  output logic        wordValid,
  output logic [15:0] wordData,
  output logic        devError,
  output logic        regReq,
  output logic        regWrite,
  output logic [3:0]  regAddr,
  output logic [15:0] regWdata,
  input  logic        regDone,
  input  logic [15:0] regRdata
);
  dpStrobe_t        stb;
  dpFlags_t         flags;
  logic [IDX_W-1:0] setupIdx;
  logic [ADDR_W-1:0] setupAddr;
  logic [7:0]       setupByte;

  ata_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lbaLoad(lbaLoad), .wordReq(wordReq),
    .regDone(regDone), .flags(flags), .setupAddr(setupAddr), .setupByte(setupByte),
    .regReq(regReq), .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .wordValid(wordValid), .devError(devError), .stb(stb), .setupIdx(setupIdx)
  );

  ata_seq_dp #(.WORDS(WORDS), .RST_HOLD(RST_HOLD)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lbaIn(lbaIn), .rdData(regRdata),
    .setupIdx(setupIdx), .flags(flags), .setupAddr(setupAddr),
    .setupByte(setupByte), .wordOut(wordData)
  );
endmodule

// File: tb/tb_ata_sector_reader.sv
`timescale 1ns/1ps
module tb_ata_sector_reader;
  localparam int HOLD = 40;
  localparam int LAT  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lbaLoad = 1'b0, wordReq = 1'b0, regDone = 1'b0;
  logic [27:0] lbaIn = '0;
  logic [15:0] regRdata = '0;
  logic wordValid, devError, regReq, regWrite;
  logic [15:0] wordData, regWdata;
  logic [3:0] regAddr;

  always #2 clk = ~clk;

  ata_sector_reader #(.WORDS(256), .RST_HOLD(HOLD)) dut (
    .clk(clk), .rstN(rstN), .lbaLoad(lbaLoad), .lbaIn(lbaIn), .wordReq(wordReq),
    .wordValid(wordValid), .wordData(wordData), .devError(devError),
    .regReq(regReq), .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regDone(regDone), .regRdata(regRdata)
  );

  int vectors = 0, fails = 0, cyc = 0, errCycles = 0;
  bit finished = 0;
  string curTag = "R1";
  logic [20:0] expQ[$];

  // card model state
  logic [27:0] devLba = '0;
  int devIdx = 0, drq = 0, busyCnt = 0, postBusy = 3, write4Cyc = 0;
  bit errFlag = 0, errAfterCmd = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (devError) errCycles <= errCycles + 1;

  function automatic logic [15:0] wordFn(logic [27:0] lba, int i);
    logic [7:0] b;
    b = 8'(i);
    return {b ^ lba[23:16] ^ {4'h0, lba[27:24]}, ~b ^ lba[7:0] ^ lba[15:8]};
  endfunction

  function automatic logic [7:0] statusFn();
    if (errFlag) return 8'h51;
    if (busyCnt > 0) begin busyCnt--; return 8'h80; end
    if (drq > 0) return 8'h58;
    return 8'h50;
  endfunction

  task automatic fail(string tag, string what, logic [31:0] got, logic [31:0] exp);
    fails++;
    $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
  endtask

  task automatic execOp();
    logic [20:0] got, e;
    got = {regWrite, regAddr, regWrite ? regWdata : 16'h0000};
    vectors++;
    if (expQ.size() == 0) fail(curTag, "unexpected register op", 32'(got), 32'h0);
    else begin
      e = expQ.pop_front();
      if (e != got) fail(curTag, "register op", 32'(got), 32'(e));
    end
    if (!regWrite) begin
      if (regAddr == 4'h7) regRdata = {8'h00, statusFn()};
      else if (regAddr == 4'h0) begin
        regRdata = wordFn(devLba, devIdx);
        devIdx++;
        if (drq > 0) drq--;
      end
    end else begin
      case (regAddr)
        4'h3: devLba[7:0]   = regWdata[7:0];
        4'h4: devLba[15:8]  = regWdata[7:0];
        4'h5: devLba[23:16] = regWdata[7:0];
        4'h6: devLba[27:24] = regWdata[3:0];
        4'h7: begin
          drq = 256; devIdx = 0; busyCnt = postBusy;
          if (errAfterCmd) begin errFlag = 1; errAfterCmd = 0; end
        end
        4'hE: if (regWdata[2]) begin
          drq = 0; errFlag = 0; busyCnt = 0; write4Cyc = cyc;
        end
        default: ;
      endcase
    end
  endtask

  // register-access engine + card
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (!rstN) begin regDone = 0; waitCnt = 0; end
      else if (regDone) regDone = 0;
      else if (regReq) begin
        if (waitCnt == 0 && regWrite && regAddr == 4'hE && regWdata[2] == 1'b0) begin
          vectors++;  // R7 hold time
          if (cyc - write4Cyc < HOLD) fail("R7", "soft-reset hold cycles", 32'(cyc - write4Cyc), 32'(HOLD));
        end
        waitCnt++;
        if (waitCnt >= LAT) begin waitCnt = 0; execOp(); regDone = 1; end
      end
    end
  end

  task automatic expRead(logic [3:0] a);  expQ.push_back({1'b0, a, 16'h0000}); endtask
  task automatic expWrite(logic [3:0] a, logic [7:0] d); expQ.push_back({1'b1, a, 8'h00, d}); endtask
  task automatic expSetup(logic [27:0] l);
    expWrite(4'h1, 8'h00); expWrite(4'h2, 8'h01);
    expWrite(4'h3, l[7:0]); expWrite(4'h4, l[15:8]); expWrite(4'h5, l[23:16]);
    expWrite(4'h6, {4'hE, l[27:24]});  // R3
    expWrite(4'h7, 8'h20);
  endtask
  task automatic expOpen(logic [27:0] l);
    expRead(4'h7); expSetup(l);
    for (int i = 0; i <= postBusy; i++) expRead(4'h7);
    expRead(4'h0);
  endtask
  task automatic expDrain(int k);
    for (int i = 0; i < k; i++) begin expRead(4'h7); expRead(4'h0); end
  endtask
  task automatic expSoftReset();
    expWrite(4'hE, 8'h04); expWrite(4'hE, 8'h00);
  endtask

  task automatic loadLba(logic [27:0] v);
    @(negedge clk); lbaIn = v; lbaLoad = 1;
    @(negedge clk); lbaLoad = 0;
  endtask

  task automatic doReq(string tag, logic [15:0] expWord);
    curTag = tag;
    @(negedge clk); wordReq = 1;
    @(negedge clk); wordReq = 0;
    for (int i = 0; i < 20000 && !wordValid; i++) @(negedge clk);
    vectors++;
    if (!wordValid) fail(tag, "no wordValid", 32'h0, 32'h1);
    else if (wordData !== expWord) fail("R11", "word data", 32'(wordData), 32'(expWord));
    @(negedge clk);
    vectors++;
    if (wordValid !== 1'b0) fail("R10", "wordValid width", 32'(wordValid), 32'h0);
    vectors++;
    if (expQ.size() != 0) fail(tag, "register ops missing", 32'(expQ.size()), 32'h0);
    expQ.delete();
  endtask

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) fail(tag, what, got, exp);
  endtask

  initial begin
    logic [27:0] lba;
    int snap;
    repeat (4) @(negedge clk);
    chk("R1", "regReq in reset", 32'(regReq), 0);
    chk("R1", "wordValid in reset", 32'(wordValid), 0);
    chk("R1", "devError in reset", 32'(devError), 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk("R1", "regReq after reset", 32'(regReq), 0);

    // first sector: setup order, drive/head, busy polling
    lba = 28'hA5C3E71;
    loadLba(lba);
    expOpen(lba);
    doReq("R2", wordFn(lba, 0));
    chk("R4", "devError during clean read", 32'(errCycles), 0);

    // open sector: data reads only
    for (int i = 1; i <= 2; i++) begin expRead(4'h0); doReq("R5", wordFn(lba, i)); end

    // new address with 253 leftovers
    lba = 28'h0123456;
    loadLba(lba);
    expDrain(253); expOpen(lba);
    doReq("R9", wordFn(lba, 0));

    // rest of sector, then automatic reopen
    for (int i = 1; i < 256; i++) begin expRead(4'h0); doReq("R5", wordFn(lba, i)); end
    expOpen(lba);
    doReq("R5", wordFn(lba, 0));

    // busy card plus 255 leftovers before the command
    lba = 28'hFEDCBA9;
    loadLba(lba);
    busyCnt = 2;
    expRead(4'h7); expRead(4'h7); expDrain(255); expOpen(lba);
    doReq("R6", wordFn(lba, 0));

    // error on the first poll
    lba = 28'h7000F0F;
    snap = errCycles;
    errFlag = 1;
    loadLba(lba);
    expRead(4'h7); expSoftReset(); expOpen(lba);
    doReq("R7", wordFn(lba, 0));
    chk("R7", "devError seen", 32'(errCycles > snap), 1);

    // error after the command, retry
    lba = 28'h3355AA1;
    snap = errCycles;
    errAfterCmd = 1;
    loadLba(lba);
    expDrain(255); expRead(4'h7); expSetup(lba); expRead(4'h7);
    expSoftReset(); expOpen(lba);
    doReq("R8", wordFn(lba, 0));
    chk("R8", "devError seen on retry", 32'(errCycles > snap), 1);
    expRead(4'h0);
    doReq("R8", wordFn(lba, 1));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL %s watchdog expired: got %0d expected %0d", curTag, 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule